// File: doc/BRIEF.md
# Timer-Linked Capture, Compare and Pulse-Width Unit

This block sits beside a free-running 16-bit timer. A 4-bit mode field in the control register selects one of three jobs. Capture mode stamps the timer value into the data register when a chosen edge arrives on the input pin. Compare mode watches for the timer to equal the data register and then drives the pin or raises an event. PWM mode produces a pulse train whose 10-bit duty value is split between the control register and the low byte of the data register. The period comes from an external timebase.

Software reaches the unit through a small four-location register port. Reads come back one clock after the address is presented. A sticky interrupt flag reports captures and compare matches. In the trigger-event compare mode, a one-clock timer-reset pulse is issued, plus a conversion-start pulse when the build includes that output and the converter enable input is high.

Top module: `ccp_unit`

## Requirements
- R1: After reset the control register, the data register, the flag, the pin output and both pulse outputs are all 0. Address 0 is control (bits 5-4 are the duty low bits, bits 3-0 are the mode). Address 1 is the data low byte, address 2 is the data high byte and address 3 is the flag in bit 0. Control bits 7-6 always read 0.
- R2: A mode of 00xx (0000 and the unused 0001-0011) disables the unit. The pin output is held low, no capture or match takes place and the edge prescale count is cleared.
- R3: Mode 0100 copies the timer value into the data register on each falling edge of the synchronised input, and mode 0101 does so on each rising edge. Each capture sets the flag, and the pin output is not changed.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. Writing a different mode value clears the edge count, so counting restarts from zero.
- R5: A match happens on the first clock in which the timer equals the data register. In mode 1000 a match drives the pin high and in mode 1001 it drives the pin low, and both set the flag.
- R6: In mode 1010 a match sets the flag and leaves the pin unchanged.
- R7: In mode 1011 a match sets the flag, leaves the pin unchanged and gives a one-clock timer-reset pulse. The conversion-start pulse appears with it only if the converter enable input was high.
- R8: Modes 11xx give PWM. The duty value D is {data[7:0], ctrl[5:4]}, and the pin is high for exactly D clocks from each period restart. D=0 keeps the pin low, and a D at or beyond the period length keeps the pin high.
- R9: A new duty value takes effect only at the next period restart, never within the period that is running.
- R10: The flag stays set until software writes address 3. A flag-setting event in the same clock wins over the clear.
- R11: Control bits 5-4 have no effect in capture and compare modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the previous clock's address |
| tmr_val | input | 16 | Free-running timer value |
| period_restart | input | 1 | PWM period start strobe from the external timebase |
| pin_in | input | 1 | Asynchronous capture input |
| pin_out | output | 1 | Driven pin |
| irq_flag | output | 1 | Sticky interrupt flag |
| tmr_reset | output | 1 | One-clock timer-reset pulse (trigger-event mode) |
| adc_enable | input | 1 | Converter enable, gates the conversion-start pulse |
| adc_start | output | 1 | One-clock conversion-start pulse |

## Verification
The hardest state to reach from the ports is a partly filled edge prescale count that is then thrown away by a mode change. The stimulus drives a number of rising edges that falls short of the prescale limit and then rewrites the mode. It then shows that capture needs a full fresh count. The PWM duty hand-over is the other hard case: the stimulus polls the timebase position and rewrites the duty halfway through a period. It then measures that period and the one after it separately.

// File: rtl/ccp_pkg.sv
`timescale 1ns/1ps
package ccp_pkg;
  // Upper two mode bits select the job, lower two refine it.
  typedef enum logic [1:0] {
    KIND_OFF     = 2'd0,
    KIND_CAPTURE = 2'd1,
    KIND_COMPARE = 2'd2,
    KIND_PWM     = 2'd3
  } ccp_kind_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DLO  = 2'd1;
  localparam logic [1:0] ADDR_DHI  = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  localparam logic [1:0] CAP_FALL  = 2'd0;
  localparam logic [1:0] CAP_RISE  = 2'd1;
  localparam logic [1:0] CAP_PREA  = 2'd2;
  localparam logic [1:0] CAP_PREB  = 2'd3;

  localparam logic [1:0] CMP_SET   = 2'd0;
  localparam logic [1:0] CMP_CLR   = 2'd1;
  localparam logic [1:0] CMP_SOFT  = 2'd2;
  localparam logic [1:0] CMP_EVT   = 2'd3;

  function automatic ccp_kind_e kind_of(input logic [3:0] mode);
    return ccp_kind_e'(mode[3:2]);
  endfunction
endpackage

// File: rtl/ccp_edge_capture.sv
`timescale 1ns/1ps
module ccp_edge_capture #(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_A       = 4,
  parameter int PRE_B       = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       enable,
  input  logic [1:0] sel,
  input  logic       pin_in,
  output logic       fire
);
  import ccp_pkg::*;

  localparam int PRE_MAX = (PRE_B > PRE_A) ? PRE_B : PRE_A;
  localparam int CNT_W   = (PRE_MAX > 2) ? $clog2(PRE_MAX) : 1;
  localparam logic [CNT_W-1:0] LAST_A = CNT_W'(PRE_A - 1);
  localparam logic [CNT_W-1:0] LAST_B = CNT_W'(PRE_B - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   rise_w, fall_w;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= pin_in;
  end

  genvar g;
  generate
    for (g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_w =  sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_w = ~sync_q[SYNC_STAGES-1] &  prev_q;

  always_comb begin
    fire = 1'b0;
    if (enable) begin
      unique case (sel)
        CAP_FALL: fire = fall_w;
        CAP_RISE: fire = rise_w;
        CAP_PREA: fire = rise_w && (cnt_q == LAST_A);
        CAP_PREB: fire = rise_w && (cnt_q == LAST_B);
        default:  fire = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt_q <= '0;
    else if (enable && sel[1] && rise_w)
      cnt_q <= fire ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ccp_compare.sv
`timescale 1ns/1ps
module ccp_compare #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             enable,
  input  logic [TMR_W-1:0] tmr,
  input  logic [TMR_W-1:0] ref_val,
  output logic             hit
);
  logic match_w, match_q;

  assign match_w = enable && (tmr == ref_val);
  assign hit     = match_w && !match_q;

  always_ff @(posedge clk) begin
    if (rst || clear) match_q <= 1'b0;
    else              match_q <= match_w;
  end
endmodule

// File: rtl/ccp_pwm.sv
`timescale 1ns/1ps
module ccp_pwm #(
  parameter int TB_W   = 8,
  parameter int FRAC_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic                   enable,
  input  logic                   restart,
  input  logic [TB_W-1:0]        tb,
  input  logic [TB_W+FRAC_W-1:0] duty,
  output logic                   pin_load,
  output logic                   pin_next
);
  localparam int DUTY_W = TB_W + FRAC_W;

  logic [FRAC_W-1:0] frac_q;
  logic [DUTY_W-1:0] shadow_q;
  logic [DUTY_W-1:0] count_w;

  assign count_w = {tb, frac_q};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      frac_q   <= '0;
      shadow_q <= '0;
    end else if (enable && restart) begin
      frac_q   <= FRAC_W'(1);
      shadow_q <= duty;
    end else begin
      frac_q   <= frac_q + 1'b1;
    end
  end

  always_comb begin
    pin_load = 1'b0;
    pin_next = 1'b0;
    if (enable) begin
      if (restart) begin
        pin_load = 1'b1;
        pin_next = |duty;
      end else if (count_w == shadow_q) begin
        pin_load = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ccp_unit.sv
`timescale 1ns/1ps
module ccp_unit
  import ccp_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_A       = 4,
  parameter int PRE_B       = 16,
  parameter bit HAS_ADC     = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [TMR_W-1:0] tmr_val,
  input  logic             period_restart,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             irq_flag,
  output logic             tmr_reset,
  input  logic             adc_enable,
  output logic             adc_start
);
  localparam int BYTE_W  = 8;
  localparam int HI_W    = TMR_W - BYTE_W;
  localparam int CTRL_W  = 6;
  localparam int FRAC_W  = 2;
  localparam int DUTY_W  = BYTE_W + FRAC_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [TMR_W-1:0]  data_q;
  logic              flag_q, pin_q, trst_q, adc_q;
  logic [7:0]        rdata_q;

  logic [3:0]        mode;
  ccp_kind_e         kind;
  logic              wr_ctrl, wr_dlo, wr_dhi, wr_flag;
  logic              mode_chg, sub_clear;
  logic              cap_fire, cmp_hit, evt_w;
  logic              pwm_load, pwm_next;
  logic [DUTY_W-1:0] duty_w;

  assign mode      = ctrl_q[3:0];
  assign kind      = kind_of(mode);
  assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_dlo    = reg_wr && (reg_addr == ADDR_DLO);
  assign wr_dhi    = reg_wr && (reg_addr == ADDR_DHI);
  assign wr_flag   = reg_wr && (reg_addr == ADDR_FLAG);
  assign mode_chg  = wr_ctrl && (reg_wdata[3:0] != mode);
  assign sub_clear = (kind == KIND_OFF) || mode_chg;
  assign duty_w    = {data_q[BYTE_W-1:0], ctrl_q[5:4]};
  assign evt_w     = cmp_hit && (mode[1:0] == CMP_EVT);

  ccp_edge_capture #(
    .SYNC_STAGES(SYNC_STAGES),
    .PRE_A      (PRE_A),
    .PRE_B      (PRE_B)
  ) u_cap (
    .clk    (clk),
    .rst    (rst),
    .clear  (sub_clear),
    .enable (kind == KIND_CAPTURE),
    .sel    (mode[1:0]),
    .pin_in (pin_in),
    .fire   (cap_fire)
  );

  ccp_compare #(
    .TMR_W(TMR_W)
  ) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .clear   (sub_clear),
    .enable  (kind == KIND_COMPARE),
    .tmr     (tmr_val),
    .ref_val (data_q),
    .hit     (cmp_hit)
  );

  ccp_pwm #(
    .TB_W  (BYTE_W),
    .FRAC_W(FRAC_W)
  ) u_pwm (
    .clk      (clk),
    .rst      (rst),
    .clear    (sub_clear),
    .enable   (kind == KIND_PWM),
    .restart  (period_restart),
    .tb       (tmr_val[BYTE_W-1:0]),
    .duty     (duty_w),
    .pin_load (pwm_load),
    .pin_next (pwm_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      data_q  <= '0;
      flag_q  <= 1'b0;
      pin_q   <= 1'b0;
      trst_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];

      if (cap_fire) begin
        data_q <= tmr_val;
      end else begin
        if (wr_dlo) data_q[BYTE_W-1:0]     <= reg_wdata;
        if (wr_dhi) data_q[TMR_W-1:BYTE_W] <= HI_W'(reg_wdata);
      end

      if (cap_fire || cmp_hit) flag_q <= 1'b1;
      else if (wr_flag)        flag_q <= 1'b0;

      if (kind == KIND_OFF)
        pin_q <= 1'b0;
      else if (cmp_hit && (mode[1:0] == CMP_SET))
        pin_q <= 1'b1;
      else if (cmp_hit && (mode[1:0] == CMP_CLR))
        pin_q <= 1'b0;
      else if (pwm_load)
        pin_q <= pwm_next;

      trst_q <= evt_w;

      unique case (reg_addr)
        ADDR_CTRL: rdata_q <= {2'b00, ctrl_q};
        ADDR_DLO:  rdata_q <= data_q[BYTE_W-1:0];
        ADDR_DHI:  rdata_q <= BYTE_W'(data_q[TMR_W-1:BYTE_W]);
        default:   rdata_q <= {7'd0, flag_q};
      endcase
    end
  end

  generate
    if (HAS_ADC) begin : g_adc
      always_ff @(posedge clk) begin
        if (rst) adc_q <= 1'b0;
        else     adc_q <= evt_w && adc_enable;
      end
    end else begin : g_no_adc
      assign adc_q = 1'b0;
    end
  endgenerate

  assign reg_rdata = rdata_q;
  assign pin_out   = pin_q;
  assign irq_flag  = flag_q;
  assign tmr_reset = trst_q;
  assign adc_start = adc_q;
endmodule

// File: rtl/ccp_unit_chk.sv
`timescale 1ns/1ps
module ccp_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       period_restart,
  input logic       pin_out,
  input logic       irq_flag,
  input logic       tmr_reset,
  input logic       adc_enable,
  input logic       adc_start,
  input logic [3:0] mode_i
);
  // R1: control bits 7-6 read back as zero
  assert_ctrl_top_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd0) |=> (reg_rdata[7:6] == 2'b00));

  // R2: disabled modes force the pin low
  assert_off_pin_low_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_i[3:2] == 2'b00) |=> !pin_out);

  // R3: capture never moves the pin
  assert_capture_pin_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i[3:2]) == 2'b01) |-> $stable(pin_out));

  // R6: software-interrupt and trigger-event modes never move the pin
  assert_event_pin_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i[3:1]) == 3'b101) |-> $stable(pin_out));

  // R7: timer reset is a single-clock pulse
  assert_trst_single_R7: assert property (@(posedge clk) disable iff (rst)
    tmr_reset |=> !tmr_reset);

  // R7: timer reset comes with the flag
  assert_trst_flag_R7: assert property (@(posedge clk) disable iff (rst)
    tmr_reset |-> irq_flag);

  // R7: conversion start needs the enable and the timer reset
  assert_adc_gated_R7: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> (tmr_reset && $past(adc_enable)));

  // R8: in PWM the pin rises only at a period restart
  assert_pwm_rise_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(pin_out) && ($past(mode_i[3:2]) == 2'b11)) |-> $past(period_restart));

  // R10: flag holds until a write to the flag location
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !(reg_wr && (reg_addr == 2'd3))) |=> irq_flag);
endmodule

bind ccp_unit ccp_unit_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .reg_wr         (reg_wr),
  .reg_addr       (reg_addr),
  .reg_rdata      (reg_rdata),
  .period_restart (period_restart),
  .pin_out        (pin_out),
  .irq_flag       (irq_flag),
  .tmr_reset      (tmr_reset),
  .adc_enable     (adc_enable),
  .adc_start      (adc_start),
  .mode_i         (ctrl_q[3:0])
);

// File: tb/ccp_unit_tb.sv
`timescale 1ns/1ps
module ccp_unit_tb;
  localparam int P = 20;          // PWM period in timer ticks
  localparam int PCLK = 4 * P;    // PWM period in clocks

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic [15:0] tmr_val;
  logic [15:0] tmr_drv = 16'd0;
  logic [7:0]  pwm_tb = 8'd0;
  logic        period_restart = 1'b0;
  logic        pin_in = 1'b0;
  logic        pin_out, irq_flag, tmr_reset, adc_start;
  logic        adc_enable = 1'b0;

  always #2.5 clk = ~clk;

  bit pwm_run = 1'b0;
  int n_pos = PCLK - 1;
  int acc = 0, last_high = 0, pcount = 0;
  int trst_cnt = 0, adc_cnt = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  assign tmr_val = pwm_run ? {8'h00, pwm_tb} : tmr_drv;

  ccp_unit u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_val(tmr_val),
    .period_restart(period_restart), .pin_in(pin_in), .pin_out(pin_out),
    .irq_flag(irq_flag), .tmr_reset(tmr_reset), .adc_enable(adc_enable),
    .adc_start(adc_start)
  );

  // External timebase model: restart on position 0, timer = position / 4
  always @(negedge clk) begin
    if (tmr_reset) trst_cnt++;
    if (adc_start) adc_cnt++;
    if (pwm_run) begin
      acc += int'(pin_out);
      if (n_pos == PCLK - 1) begin
        last_high = acc;
        acc = 0;
        pcount++;
        n_pos = 0;
      end else begin
        n_pos++;
      end
      period_restart = (n_pos == 0);
      pwm_tb = 8'(n_pos / 4);
    end else begin
      period_restart = 1'b0;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    reg_addr = 2'(a);
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  task automatic rd_data(output int d);
    int lo, hi;
    rd(1, lo);
    rd(2, hi);
    d = (hi << 8) | lo;
  endtask

  task automatic pin_edge(bit v);
    @(negedge clk);
    pin_in = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic match_pulse(int x);
    @(negedge clk); tmr_drv = 16'(x);
    @(negedge clk); tmr_drv = 16'(x ^ 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_period();
    int c = pcount;
    while (pcount == c) @(posedge clk);
  endtask

  task automatic set_duty(int d);
    wr(1, (d >> 2) & 8'hFF);
    wr(0, 8'h0C | ((d & 3) << 4));
  endtask

  function automatic int exp_high(int d);
    if (d == 0) return 0;
    if (d >= PCLK) return PCLK;
    return d;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int v, d, x, t, m, lb, d1, d2;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state and map
    rd(0, v); chk("R1 ctrl", v, 0);
    rd_data(v); chk("R1 data", v, 0);
    rd(3, v); chk("R1 flag", v, 0);
    chk("R1 pin", pin_out, 0);
    chk("R1 trst", tmr_reset, 0);
    wr(0, 8'hC5);
    rd(0, v); chk("R1 top bits read zero", v, 8'h05);
    wr(0, 0);

    // R2 unused mode 0011 is disabled
    tmr_drv = 16'h1234;
    wr(0, 8'h03);
    pin_edge(1); pin_edge(0);
    chk("R2 no flag when off", irq_flag, 0);
    rd_data(v); chk("R2 data untouched", v, 0);
    chk("R2 pin low", pin_out, 0);

    // R3 rising capture, falling ignored
    wr(0, 8'h05); tmr_drv = 16'hA5C3;
    pin_edge(1);
    rd_data(v); chk("R3 rising capture", v, 16'hA5C3);
    chk("R3 flag", irq_flag, 1);
    wr(3, 0);
    chk("R10 flag cleared", irq_flag, 0);
    tmr_drv = 16'h0F0F;
    pin_edge(0);
    rd_data(v); chk("R3 falling ignored in rise mode", v, 16'hA5C3);
    // R3 falling capture
    wr(0, 8'h04);
    tmr_drv = 16'h7777; pin_edge(1);
    rd_data(v); chk("R3 rising ignored in fall mode", v, 16'hA5C3);
    tmr_drv = 16'h3C3C; pin_edge(0);
    rd_data(v); chk("R3 falling capture", v, 16'h3C3C);
    wr(3, 0);

    // R3 / R11 random capture runs with random duty bits
    for (int i = 0; i < 6; i++) begin
      m = int'($urandom_range(0, 1));
      lb = int'($urandom_range(0, 3));
      t = int'($urandom & 16'hFFFF);
      wr(0, 0);
      pin_edge(m == 0 ? 1'b1 : 1'b0);
      wr(3, 0);
      wr(0, (lb << 4) | 4 | m);
      tmr_drv = 16'(t);
      pin_edge(m == 0 ? 1'b0 : 1'b1);
      rd_data(v); chk("R3 R11 random capture", v, t);
      chk("R3 random flag", irq_flag, 1);
    end
    wr(0, 0); pin_edge(0); wr(3, 0);

    // R4 every 4th rising edge
    wr(0, 8'h06);
    for (int i = 1; i <= 3; i++) begin
      tmr_drv = 16'(100 + i); pin_edge(1); pin_edge(0);
    end
    chk("R4 no capture before 4th", irq_flag, 0);
    tmr_drv = 16'd200; pin_edge(1); pin_edge(0);
    chk("R4 capture on 4th", irq_flag, 1);
    rd_data(v); chk("R4 value on 4th", v, 200);
    wr(3, 0);
    // R4 every 16th
    wr(0, 8'h07);
    for (int i = 1; i <= 15; i++) begin
      tmr_drv = 16'(300 + i); pin_edge(1); pin_edge(0);
    end
    chk("R4 no capture before 16th", irq_flag, 0);
    tmr_drv = 16'd999; pin_edge(1); pin_edge(0);
    rd_data(v); chk("R4 value on 16th", v, 999);
    wr(3, 0);
    // R4 mode change clears the count
    for (int i = 0; i < 5; i++) begin pin_edge(1); pin_edge(0); end
    wr(0, 8'h06);
    for (int i = 0; i < 3; i++) begin pin_edge(1); pin_edge(0); end
    chk("R4 count restarted after mode change", irq_flag, 0);
    tmr_drv = 16'd4321; pin_edge(1); pin_edge(0);
    rd_data(v); chk("R4 fresh 4th after mode change", v, 4321);
    wr(3, 0);

    // R5 compare set / clear
    wr(0, 0);
    x = 16'h5A01;
    tmr_drv = 16'(~x);
    wr(1, x & 8'hFF); wr(2, x >> 8);
    wr(0, 8'h38);
    repeat (3) @(negedge clk);
    chk("R5 no match yet", irq_flag, 0);
    match_pulse(x);
    chk("R5 set on match", pin_out, 1);
    chk("R5 flag on match", irq_flag, 1);
    wr(3, 0);
    wr(0, 8'h09);
    repeat (3) @(negedge clk);
    chk("R5 pin held before match", pin_out, 1);
    match_pulse(x);
    chk("R5 clear on match", pin_out, 0);
    wr(0, 8'h08); match_pulse(x);
    chk("R5 set again", pin_out, 1);

    // R6 soft interrupt keeps the pin
    wr(3, 0);
    wr(0, 8'h0A); match_pulse(x);
    chk("R6 flag set", irq_flag, 1);
    chk("R6 pin unchanged", pin_out, 1);

    // R7 trigger event
    wr(3, 0);
    adc_enable = 1'b0;
    wr(0, 8'h0B);
    trst_cnt = 0; adc_cnt = 0;
    match_pulse(x);
    chk("R7 timer reset pulse", trst_cnt, 1);
    chk("R7 no conversion when disabled", adc_cnt, 0);
    chk("R7 flag", irq_flag, 1);
    chk("R7 pin unchanged", pin_out, 1);
    adc_enable = 1'b1;
    match_pulse(x);
    chk("R7 second pulse", trst_cnt, 2);
    chk("R7 conversion when enabled", adc_cnt, 1);
    adc_enable = 1'b0;

    // R10 flag held across other writes
    wr(1, x & 8'hFF);
    chk("R10 flag held", irq_flag, 1);
    rd(3, v); chk("R10 flag readback", v, 1);
    wr(3, 0);

    // R2 leaving compare drives pin low
    wr(0, 0);
    @(negedge clk);
    chk("R2 pin low when off", pin_out, 0);

    // R5 / R11 random compare
    for (int i = 0; i < 8; i++) begin
      m = int'($urandom_range(0, 1));
      lb = int'($urandom_range(0, 3));
      x = int'($urandom & 16'hFFFF);
      wr(0, 0); wr(3, 0);
      tmr_drv = 16'(x ^ 16'h5A5A);
      wr(1, x & 8'hFF); wr(2, x >> 8);
      wr(0, (lb << 4) | 8 | m);
      match_pulse(x);
      chk("R5 R11 random compare pin", pin_out, (m == 0) ? 1 : 0);
      chk("R5 random flag", irq_flag, 1);
    end
    wr(0, 0); wr(3, 0);

    // R8 PWM duty values
    tmr_drv = 16'd0;
    pwm_run = 1'b1;
    for (int i = 0; i < 9; i++) begin
      case (i)
        0: d = 0;
        1: d = 1;
        2: d = 37;
        3: d = PCLK;
        4: d = 1023;
        5: d = PCLK - 1;
        default: d = int'($urandom_range(2, PCLK - 2));
      endcase
      set_duty(d);
      wait_period(); wait_period();
      chk("R8 high time", last_high, exp_high(d));
    end

    // R9 duty change only at restart
    d1 = 25; d2 = 61;
    set_duty(d1);
    wait_period(); wait_period();
    while (n_pos != 2 * P) @(posedge clk);
    set_duty(d2);
    wait_period();
    chk("R9 running period keeps old duty", last_high, d1);
    wait_period();
    chk("R9 next period takes new duty", last_high, d2);

    pwm_run = 1'b0;
    wr(0, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule